// File: doc/BRIEF.md
# Latched Interrupt Aggregator with Read-Clear

This block gathers single-cycle event pulses from eight peripheral sources and turns them into one active-high interrupt line toward a host processor. Each source has its own enable bit, and a single global enable bit gates the whole output. An event whose source is enabled, arriving while the global enable is on, sets its flag in an identification register. The flag stays set until the host reads that register.

The interrupt line is high whenever any flag is set and the global enable is on. The host reads the identification register with a one-cycle read strobe. In that cycle it sees the contents from before the read, and the register clears on the following clock edge. An event that arrives in the same cycle as the read survives the clear. Events from disabled sources are dropped and are never stored for later delivery. Register writes go to one of two targets, chosen by a select bit: the per-source enable mask or the global control bit. Address decoding takes place outside the block.

Top module: `irq_aggregator`

## Requirements
- R1: When reset is asserted, the interrupt line goes low at once. While reset is held, the identification register reads 0x00, the per-source mask is 0x00 and the global enable is off.
- R2: An event pulse on source i, with mask bit i set and the global enable on, sets bit i of the identification register. The interrupt line is high after the next clock edge.
- R3: An event pulse on a source whose mask bit is clear is discarded. It never appears in the identification register, either then or after the source is enabled later.
- R4: Flags accumulate. Every enabled event since the last read is ORed into the register, and flags already set remain set.
- R5: Without a read, the interrupt line and the set flags hold. During a read cycle (`rd_id`=1), `rd_data` shows the contents from before the clear. After that clock edge the register is 0x00 and the line is low, unless R6 applies.
- R6: An enabled event that arrives in the same cycle as a read is present in the register after the clear.
- R7: While the global enable is off, the interrupt line is low and no new event is latched. Flags that are already set are kept, and the line rises again once the global enable is turned back on.
- R8: A write with `wr_sel`=0 loads `wr_data` as the per-source mask (bit i enables source i). A write with `wr_sel`=1 loads `wr_data[0]` as the global enable. A written value governs events from the cycle after the write onward. An event in the write cycle itself is judged against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| event_i | input | 8 | One-cycle event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = per-source mask, 1 = global control |
| wr_data | input | 8 | Write data |
| rd_id | input | 1 | Identification read strobe; clears the register at the next edge |
| rd_data | output | 8 | Identification register contents |
| irq_o | output | 1 | Active-high interrupt line |

## Verification
A flag that is wrongly set or wrongly lost shows up at `rd_data` one clock edge after the event or read that caused it. In most cases it also shows up at `irq_o`, unless other flags are already holding the line high. A mask or global-enable bit that is stored wrongly stays hidden until an event arrives on the affected source. For that reason the vectors send events on both enabled and disabled sources after every change to the enables. A clear that is late or missing is caught on the edge right after the read strobe.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_SRC  = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SYNC_LEN = 2;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_CTRL = 1'b1
  } wr_target_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [N-1:0]  mask_o,
  output logic          glb_en_o
);
  logic [N-1:0] mask_q, mask_d;
  logic         glb_q, glb_d;
  logic         mask_ce, glb_ce;

  always_comb begin
    mask_ce = wr_en && (wr_target_e'(wr_sel) == SEL_MASK);
    glb_ce  = wr_en && (wr_target_e'(wr_sel) == SEL_CTRL);
    mask_d  = wr_data[N-1:0];
    glb_d   = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_q <= 1'b0;
    else if (glb_ce) glb_q <= glb_d;
  end

  assign mask_o   = mask_q;
  assign glb_en_o = glb_q;
endmodule

// File: rtl/irq_id_latch.sv
module irq_id_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] mask_i,
  input  logic         glb_en_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q, flag_d, accept;

  for (genvar g = 0; g < N; g++) begin : g_src
    always_comb begin
      accept[g] = event_i[g] & mask_i[g] & glb_en_i;
      flag_d[g] = (flag_q[g] & ~rd_clr_i) | accept[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N      = NUM_SRC,
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned STAGES = SYNC_LEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  event_i,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_id,
  output logic [N-1:0]  rd_data,
  output logic          irq_o
);
  logic         rst_n_sync;
  logic [N-1:0] mask;
  logic         glb_en;
  logic [N-1:0] flags;

  irq_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  irq_enable_regs #(.N(N), .DW(DW)) u_en (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mask_o(mask), .glb_en_o(glb_en)
  );

  irq_id_latch #(.N(N)) u_id (
    .clk(clk), .rst_n(rst_n_sync), .event_i(event_i), .mask_i(mask),
    .glb_en_i(glb_en), .rd_clr_i(rd_id), .flags_o(flags)
  );

  assign rd_data = flags;
  assign irq_o   = glb_en & (|flags);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n_sync,
  input logic [N-1:0] event_i,
  input logic [N-1:0] mask,
  input logic         glb_en,
  input logic         rd_id,
  input logic [N-1:0] rd_data,
  input logic         irq_o
);
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (glb_en && ((event_i & mask) != '0)) |=>
      ((rd_data & $past(event_i & mask)) == $past(event_i & mask)));

  p_irq_high_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (glb_en && (rd_data != '0)) |-> irq_o);

  p_no_stray_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    1'b1 |=> ((rd_data & ~$past(rd_data) & ~($past(event_i & mask) & {N{$past(glb_en)}})) == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !rd_id |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rd_id |=> (rd_data == ($past(event_i & mask) & {N{$past(glb_en)}})));

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !glb_en |-> !irq_o);
endmodule

bind irq_aggregator irq_aggregator_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .event_i(event_i), .mask(mask),
  .glb_en(glb_en), .rd_id(rd_id), .rd_data(rd_data), .irq_o(irq_o)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // vector: wr_en, wr_sel, wr_data[7:0], event[7:0], rd, exp_id[7:0], exp_irq
  typedef struct packed {
    logic       we;
    logic       ws;
    logic [7:0] wd;
    logic [7:0] ev;
    logic       rd;
    logic [7:0] eid;
    logic       eirq;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h0F, 8'h00, 1'b0, 8'h00, 1'b0}, // R8 mask write
    '{1'b1, 1'b1, 8'h01, 8'h00, 1'b0, 8'h00, 1'b0}, // R8 global on
    '{1'b0, 1'b0, 8'h00, 8'h10, 1'b0, 8'h00, 1'b0}, // R3 disabled src
    '{1'b0, 1'b0, 8'h00, 8'h01, 1'b0, 8'h01, 1'b1}, // R2
    '{1'b0, 1'b0, 8'h00, 8'h04, 1'b0, 8'h05, 1'b1}, // R4
    '{1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h05, 1'b1}, // R5 hold
    '{1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0}, // R5 clear
    '{1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b0}, // R3 not kept for later
    '{1'b0, 1'b0, 8'h00, 8'h10, 1'b0, 8'h10, 1'b1}, // R2
    '{1'b0, 1'b0, 8'h00, 8'h02, 1'b1, 8'h02, 1'b1}, // R6
    '{1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0}, // R5
    '{1'b0, 1'b0, 8'h00, 8'h80, 1'b0, 8'h80, 1'b1}, // R2
    '{1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 8'h80, 1'b0}, // R7 gate
    '{1'b0, 1'b0, 8'h00, 8'h01, 1'b0, 8'h80, 1'b0}, // R7 no latch
    '{1'b1, 1'b1, 8'h01, 8'h00, 1'b0, 8'h80, 1'b1}, // R7 restore
    '{1'b1, 1'b0, 8'h00, 8'h40, 1'b0, 8'hC0, 1'b1}, // R8 old mask in write cycle
    '{1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 8'hC0, 1'b1}, // R8 new mask
    '{1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0}  // R5
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] event_i;
  logic       wr_en;
  logic       wr_sel;
  logic [7:0] wr_data;
  logic       rd_id;
  logic [7:0] rd_data;
  logic       irq_o;
  int         n_chk;
  int         n_bad;
  logic       done;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_id(rd_id),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] id_exp, input logic irq_exp);
    n_chk++;
    if (rd_data !== id_exp || irq_o !== irq_exp) begin
      n_bad++;
      $display("FAIL %s: id=%02h irq=%b expected id=%02h irq=%b",
               req, rd_data, irq_o, id_exp, irq_exp);
    end
  endtask

  task automatic idle();
    event_i = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_id = 1'b0;
  endtask

  task automatic step(input logic we, input logic ws, input logic [7:0] wd,
                      input logic [7:0] ev, input logic rd);
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd; event_i = ev; rd_id = rd;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_bad = 0;
    idle();
    do_reset();
    check("R1", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].we, VECS[i].ws, VECS[i].wd, VECS[i].ev, VECS[i].rd);
      check($sformatf("R-vec%0d", i), VECS[i].eid, VECS[i].eirq);
    end

    // R5: the read cycle shows contents from before the clear
    step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
    step(1'b0, 1'b0, 8'h00, 8'h24, 1'b0);
    @(negedge clk);
    rd_id = 1'b1;
    #1;
    check("R5 pre-clear read", 8'h24, 1'b1);
    @(posedge clk);
    #1;
    idle();
    check("R5 cleared", 8'h00, 1'b0);

    // R1: asynchronous reset mid-run with flags set
    step(1'b0, 1'b0, 8'h00, 8'h03, 1'b0);
    check("R2 before reset", 8'h03, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async", 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: mask and global enable cleared by reset
    step(1'b0, 1'b0, 8'h00, 8'hFF, 1'b0);
    check("R1 enables cleared", 8'h00, 1'b0);
    step(1'b1, 1'b1, 8'h01, 8'h00, 1'b0);
    step(1'b0, 1'b0, 8'h00, 8'hFF, 1'b0);
    check("R1 mask cleared", 8'h00, 1'b0);
    step(1'b1, 1'b1, 8'hFE, 8'h00, 1'b0);
    step(1'b1, 1'b0, 8'h01, 8'h00, 1'b0);
    step(1'b0, 1'b0, 8'h00, 8'h01, 1'b0);
    check("R8 ctrl bit0 only", 8'h00, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule